// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is a purely combinational integer arithmetic logic unit for a simple processor datapath. Two operands and a three-bit function code enter; one result word and a zero indication leave in the same cycle, with no register anywhere on the path. The datapath width is a parameter, and its default is 32 bits.

The function code is split into two fields. The top bit conditions the second operand: when it is set, the second operand is complemented before it reaches either the bitwise path or the adder, and the adder receives a carry-in of one. The same adder therefore yields the sum or the difference, and the same bitwise gates yield AND/OR or AND-NOT/OR-NOT. The two low bits choose what reaches the output: the bitwise AND, the bitwise OR, the adder output, or the sign bit of the adder output padded with zeros. The sign bit is only meaningful as a less-than result when the top bit of the code is set. The adder is a parallel-prefix carry network, so its depth grows with the logarithm of the width.

Top module: `alu_f3`

## Requirements
- R1: Code 3'b000 drives y with a AND b, and code 3'b001 drives y with a OR b.
- R2: Code 3'b010 drives y with a + b modulo 2^WIDTH, and the carry out of the top bit is discarded.
- R3: Code 3'b100 drives y with a AND (NOT b), and code 3'b101 drives y with a OR (NOT b).
- R4: Code 3'b110 drives y with a - b modulo 2^WIDTH, formed as a + (NOT b) + 1.
- R5: Code 3'b111 drives y[0] with bit WIDTH-1 of (a - b) mod 2^WIDTH and drives y[WIDTH-1:1] with zero. For a = 25 and b = 32, y is 1.
- R6: The less-than code applies no signed-overflow correction: a = 0x80000000 with b = 1 gives y = 0, and a = 0x7FFFFFFF with b = 0xFFFFFFFF gives y = 1.
- R7: Code 3'b011 drives y with all zeros whatever a and b are.
- R8: zero is 1 exactly when every bit of y is 0.
- R9: The outputs depend only on the present inputs. A change of a, b or f is visible at y and zero with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand, complemented when f[2] is set |
| f | input | 3 | Function code: bit 2 complements b and sets the carry-in, bits 1:0 choose the result |
| y | output | WIDTH | Result word |
| zero | output | 1 | High when y is all zeros |

## Verification
The bench aims at the carry chain with operands that make a carry ripple through every column, such as all-ones plus one and zero minus one. A prefix network with a missing or misplaced cell gives a wrong sum only in those high columns. The less-than code is driven with operand pairs that straddle the signed overflow boundary, where a design that corrected for overflow, or that read the carry instead of the sign bit, flips its answer. The unused code gets operands that would make every other path non-zero, so that a mux that falls through to an active path shows up at once. The zero flag is checked on every vector, both on results that are genuinely zero and on results that have only the top bit or only the bottom bit set.

// File: rtl/alu_f3_pkg.sv
package alu_f3_pkg;

  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_NONE = 3'b011,
    FN_ANDN = 3'b100,
    FN_ORN  = 3'b101,
    FN_SUB  = 3'b110,
    FN_LTS  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_LT  = 2'b11
  } alu_sel_e;

  // Top bit of the code: complement b and inject a carry.
  function automatic logic fn_inverts(input logic [2:0] code);
    return code[2];
  endfunction

  // Low field of the code: which path reaches the output.
  function automatic alu_sel_e fn_select(input logic [2:0] code);
    return alu_sel_e'(code[1:0]);
  endfunction

  // The one code whose output is forced to zero.
  function automatic logic fn_is_dead(input logic [2:0] code);
    return code == FN_NONE;
  endfunction

  // Prefix operator: combine an upper span (g_hi, p_hi) with a lower span.
  function automatic logic [1:0] gp_merge(input logic g_hi, input logic p_hi,
                                          input logic g_lo, input logic p_lo);
    return {g_hi | (p_hi & g_lo), p_hi & p_lo};
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_raw,
  input  logic             invert,
  output logic [WIDTH-1:0] b_eff,
  output logic             carry_in
);

  // Per-bit conditional complement.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_eff[i] = b_raw[i] ^ invert;
  end

  // Subtraction needs +1 on top of the complement.
  assign carry_in = invert;

endmodule

// File: rtl/alu_prefix_adder.sv
module alu_prefix_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);
  import alu_f3_pkg::*;

  // Column 0 of the prefix network holds the carry-in; column k+1 holds
  // operand bit k. Only bits 0..WIDTH-2 feed the network, since the carry
  // out of the top bit is dropped.
  localparam int COLS   = WIDTH;
  localparam int STAGES = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [COLS-1:0] g_lvl [0:STAGES];
  logic [COLS-1:0] p_lvl [0:STAGES];
  logic [WIDTH-1:0] half_sum;

  assign half_sum = op_a ^ op_b;

  // Level 0: per-column generate and propagate.
  assign g_lvl[0][0] = cin;
  assign p_lvl[0][0] = 1'b0;
  for (genvar k = 0; k < COLS - 1; k++) begin : g_col
    assign g_lvl[0][k+1] = op_a[k] & op_b[k];
    assign p_lvl[0][k+1] = op_a[k] | op_b[k];
  end

  // Parallel-prefix levels: span doubles at each level.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int DIST = 1 << s;
    for (genvar j = 0; j < COLS; j++) begin : g_node
      if (j >= DIST) begin : g_black
        logic [1:0] gp;
        assign gp = gp_merge(g_lvl[s][j], p_lvl[s][j],
                             g_lvl[s][j-DIST], p_lvl[s][j-DIST]);
        assign g_lvl[s+1][j] = gp[1];
        assign p_lvl[s+1][j] = gp[0];
      end else begin : g_pass
        assign g_lvl[s+1][j] = g_lvl[s][j];
        assign p_lvl[s+1][j] = p_lvl[s][j];
      end
    end
  end

  // Carry into bit k is the generate spanning columns k..0.
  for (genvar k = 0; k < WIDTH; k++) begin : g_sum
    assign sum[k] = half_sum[k] ^ g_lvl[STAGES][k];
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] and_out,
  output logic [WIDTH-1:0] or_out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_out[i] = op_a[i] & op_b[i];
    assign or_out[i]  = op_a[i] | op_b[i];
  end

endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       code,
  input  logic [WIDTH-1:0] and_in,
  input  logic [WIDTH-1:0] or_in,
  input  logic [WIDTH-1:0] sum_in,
  output logic [WIDTH-1:0] result,
  output logic             lt_bit
);
  import alu_f3_pkg::*;

  // Less-than is the raw sign of the difference; no overflow fix-up.
  assign lt_bit = sum_in[WIDTH-1];

  always_comb begin
    result = '0;
    if (!fn_is_dead(code)) begin
      unique case (fn_select(code))
        SEL_AND: result = and_in;
        SEL_OR:  result = or_in;
        SEL_SUM: result = sum_in;
        SEL_LT:  result = {{(WIDTH-1){1'b0}}, lt_bit};
        default: result = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_f3.sv
module alu_f3 #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       f,
  output logic [WIDTH-1:0] y,
  output logic             zero
);
  import alu_f3_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0] b_eff;
  logic             carry_in;
  logic [WIDTH-1:0] adder_sum;
  logic [WIDTH-1:0] and_path;
  logic [WIDTH-1:0] or_path;
  logic             lt_bit;

  alu_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .b_raw    (b),
    .invert   (fn_inverts(f)),
    .b_eff    (b_eff),
    .carry_in (carry_in)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_a    (a),
    .op_b    (b_eff),
    .and_out (and_path),
    .or_out  (or_path)
  );

  alu_prefix_adder #(.WIDTH(WIDTH)) u_add (
    .op_a (a),
    .op_b (b_eff),
    .cin  (carry_in),
    .sum  (adder_sum)
  );

  alu_result_mux #(.WIDTH(WIDTH)) u_mux (
    .code   (f),
    .and_in (and_path),
    .or_in  (or_path),
    .sum_in (adder_sum),
    .result (y),
    .lt_bit (lt_bit)
  );

  assign zero = ~|y;

endmodule

// File: rtl/alu_f3_chk.sv
module alu_f3_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [2:0]       f,
  input logic [WIDTH-1:0] adder_sum,
  input logic             lt_bit,
  input logic [WIDTH-1:0] y,
  input logic             zero
);

  always_comb begin
    if (!$isunknown({a, b, f})) begin
      p_and_or_r1: assert (f != 3'b000 || y == (a & b))
        else $error("R1 and path mismatch");
      p_adder_sum_r2: assert (f[2] || adder_sum == WIDTH'(a + b))
        else $error("R2 adder sum mismatch");
      p_orn_r3: assert (f != 3'b101 || y == (a | ~b))
        else $error("R3 or-not mismatch");
      p_adder_diff_r4: assert (!f[2] || adder_sum == WIDTH'(a - b))
        else $error("R4 adder difference mismatch");
      p_lts_upper_r5: assert (f != 3'b111 || $countones(y) == 32'(lt_bit))
        else $error("R5 less-than padding mismatch");
      p_dead_code_r7: assert (f != 3'b011 || $countones(y) == 0)
        else $error("R7 unused code not zero");
      p_zero_flag_r8: assert (zero == ($countones(y) == 0))
        else $error("R8 zero flag mismatch");
    end
  end

endmodule

bind alu_f3 alu_f3_chk #(.WIDTH(WIDTH)) u_chk (
  .a         (a),
  .b         (b),
  .f         (f),
  .adder_sum (adder_sum),
  .lt_bit    (lt_bit),
  .y         (y),
  .zero      (zero)
);

// File: tb/tb_alu_f3.sv
`timescale 1ns/1ps
module tb_alu_f3;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   f = 3'b000;
  logic [W-1:0] y;
  logic         zero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1F2E3D4C;

  always #2 clk = ~clk;  // 250 MHz

  alu_f3 #(.WIDTH(W)) dut (.a(a), .b(b), .f(f), .y(y), .zero(zero));

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Independent model, written from the requirements.
  function automatic logic [W-1:0] model(input logic [2:0] code,
                                         input logic [W-1:0] x,
                                         input logic [W-1:0] z);
    logic [W:0] wide;
    case (code)
      3'b000: return x & z;                   // R1
      3'b001: return x | z;                   // R1
      3'b010: begin wide = {1'b0, x} + {1'b0, z}; return wide[W-1:0]; end // R2
      3'b100: return x & ~z;                  // R3
      3'b101: return x | ~z;                  // R3
      3'b110: return x - z;                   // R4
      3'b111: begin wide = {1'b0, x - z}; return W'(wide[W-1]); end      // R5 R6
      default: return '0;                     // R7
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] code);
    case (code)
      3'b000, 3'b001: return "R1";
      3'b010:         return "R2";
      3'b100, 3'b101: return "R3";
      3'b110:         return "R4";
      3'b111:         return "R5";
      default:        return "R7";
    endcase
  endfunction

  task automatic check_vec(input string req, input logic [W-1:0] exp_y);
    checks++;
    if (y !== exp_y) begin
      errors++;
      $display("FAIL %s f=%b a=%h b=%h y actual=%h expected=%h",
               req, f, a, b, y, exp_y);
    end
    checks++;
    if (zero !== (exp_y == '0)) begin  // R8
      errors++;
      $display("FAIL R8 f=%b a=%h b=%h zero actual=%b expected=%b",
               f, a, b, zero, (exp_y == '0));
    end
  endtask

  task automatic apply(input logic [2:0] code, input logic [W-1:0] x,
                       input logic [W-1:0] z, input string req);
    @(negedge clk);
    f = code; a = x; b = z;
    #1;
    check_vec(req, model(code, x, z));
  endtask

  logic [W-1:0] edges [0:9];

  initial begin
    edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001;
    edges[2] = 32'h7FFF_FFFF; edges[3] = 32'h8000_0000;
    edges[4] = 32'hFFFF_FFFF; edges[5] = 32'h0000_0019;
    edges[6] = 32'h0000_0020; edges[7] = 32'h5555_5555;
    edges[8] = 32'hAAAA_AAAA; edges[9] = 32'h8000_0001;

    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Initial state with all-zero inputs: AND of zeros.
    @(negedge clk); #1;
    check_vec("R1", '0);

    // Named corner vectors.
    apply(3'b111, 32'd25, 32'd32, "R5");                 // expect 1
    apply(3'b111, 32'h8000_0000, 32'd1, "R6");           // overflow, expect 0
    apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R6");   // overflow, expect 1
    apply(3'b010, 32'hFFFF_FFFF, 32'd1, "R2");           // full carry ripple, zero
    apply(3'b110, 32'd0, 32'd1, "R4");                   // borrow through all bits
    apply(3'b110, 32'h1234_5678, 32'h1234_5678, "R4");   // zero result
    apply(3'b011, 32'hFFFF_FFFF, 32'h0000_0001, "R7");   // unused code
    apply(3'b011, 32'h8000_0000, 32'h7FFF_FFFF, "R7");
    apply(3'b000, 32'h8000_0000, 32'hFFFF_FFFF, "R8");   // only top bit set

    // R9: change inputs without any clock edge in between.
    @(negedge clk);
    f = 3'b010; a = 32'd7; b = 32'd8; #0.5;
    check_vec("R9", 32'd15);
    a = 32'd100; #0.5;
    check_vec("R9", 32'd108);
    f = 3'b100; #0.5;
    check_vec("R9", 32'd100 & ~32'd8);

    // Sweep every code over every pair of edge operands.
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          apply(3'(c), edges[i], edges[j], tag_of(3'(c)));
        end
      end
    end

    // Pseudo-random operands for every code.
    for (int c = 0; c < 8; c++) begin
      for (int n = 0; n < 300; n++) begin
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        rng = next_rand(rng); ra = rng;
        rng = next_rand(rng); rb = rng;
        if (n % 5 == 0) rb = ra;  // force equal operands sometimes
        apply(3'(c), ra, rb, tag_of(3'(c)));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule